// File: doc/BRIEF.md
# Serial flash status-register protection logic

This block holds the 16-bit status and control word of a serial NOR flash and decides, cycle by cycle, whether each decoded command may proceed. Upstream logic turns opcodes into one-cycle strobes for write enable, write disable, status write, page program, sector erase, block erase and chip erase. Program and erase strobes come with a byte address. The block answers every strobe it serves with a one-cycle accept or reject flag. It updates the write-enable latch and the stored status fields. For the duration of a status write, program or erase it raises a busy bit, which an internal cycle counter times.

Status writes pass through a two-bit protect mode that works with the active-low write-protect pin. One mode is a lockdown that a power-cycle event undoes, and another mode is permanent. Program and erase targets are checked against a protected region that the block-protect field selects. Chip erase is refused unless that field is entirely clear.

Top module: `flash_sr_guard`

## Requirements
- R1: After reset the status word reads 0x0000 and no accept or reject flag is raised. The status bits are: bit 0 busy, bit 1 write-enable latch, bits 6:2 block-protect field (bit 2 is its LSB), bits 8:7 protect mode (bit 8 is its MSB), bits 15:9 stored only.
- R2: A served write enable sets bit 1 and a served write disable clears it. Flag vectors use the index order 0 write enable, 1 write disable, 2 status write, 3 page program, 4 sector erase, 5 block erase, 6 chip erase. A flag rises on the clock edge that samples the strobe and lasts one cycle.
- R3: While bit 1 is 0, a status write, program or erase is rejected and nothing changes.
- R4: With protect mode 00 and bit 1 set, a status write is accepted whatever the pin level. It loads bits 15:2 from the data word, and data bits 1:0 are ignored.
- R5: With protect mode 01, a status write is rejected while the pin is low and accepted while it is high, provided bit 1 is set.
- R6: With protect mode 10 every status write is rejected, and a power-cycle event returns the mode to 00.
- R7: With protect mode 11 every status write is rejected, and a power-cycle event leaves the mode at 11.
- R8: A power-cycle event clears bits 1:0 and cancels any timed operation. It keeps bits 15:2, apart from the 10-to-00 reversion. A strobe in the same cycle is dropped with no flag.
- R9: The address is 19 bits, and bits 18:16 select one of 8 blocks. A nonzero value N in bits 4:2 protects the top min(2^(N-1), 8) blocks. Page program, sector erase and block erase aimed at a protected block are rejected. Bits 6:5 do not affect the map.
- R10: Chip erase is accepted only when bits 6:2 are all zero.
- R11: An accepted status write, program or erase holds bit 0 high for BUSY_CYCLES cycles (default 8). Bit 1 clears when bit 0 falls. Any strobe that arrives while bit 0 is high, including one in its last busy cycle, is rejected with no effect.
- R12: When several strobes arrive together, only the lowest-index strobe is served. The others raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| wrsr_data | input | 16 | Data word for a status write |
| cmd_pp | input | 1 | Page-program strobe |
| cmd_se | input | 1 | Sector-erase strobe |
| cmd_be | input | 1 | Block-erase strobe |
| cmd_ce | input | 1 | Chip-erase strobe |
| cmd_addr | input | 19 | Target byte address of program or erase |
| wp_n | input | 1 | Write-protect pin, active low |
| power_cycle | input | 1 | Power-down/power-up event pulse |
| status_o | output | 16 | Status word |
| accept_o | output | 7 | Per-command accept flags |
| reject_o | output | 7 | Per-command reject flags |

## Verification
Two pairs of events can share a cycle: the last busy cycle with a fresh strobe, and a power-cycle event with a strobe. The bench issues a write enable on exactly the BUSY_CYCLES-th cycle after an accepted operation. It expects a reject there and an accept one cycle later. A power-cycle event is paired with a write enable, and again with a running erase. The bench judges these from the status word and both flag vectors against its own model. Random runs mix these collisions with rare lockdown and permanent-lock writes.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;
  localparam int NCMD = 7;

  typedef enum logic [2:0] {
    C_WREN = 3'd0, C_WRDI = 3'd1, C_WRSR = 3'd2, C_PP = 3'd3,
    C_SE = 3'd4, C_BE = 3'd5, C_CE = 3'd6
  } cmd_e;

  localparam int B_WIP  = 0;
  localparam int B_WEL  = 1;
  localparam int B_BPLO = 2;
  localparam int B_SRP0 = 7;
  localparam int B_SRP1 = 8;

  // Is block blk inside the top region chosen by the low block-protect bits?
  function automatic logic in_protected(input int unsigned blk,
                                        input logic [2:0] bp,
                                        input int unsigned nblk);
    int unsigned cnt;
    if (bp == 3'd0) return 1'b0;
    cnt = 32'd1 << (32'(bp) - 32'd1);
    if (cnt > nblk) cnt = nblk;
    return blk >= (nblk - cnt);
  endfunction

  // Does the protect mode together with the pin allow a status write?
  function automatic logic srp_permits(input logic [1:0] srp, input logic wp_n);
    case (srp)
      2'b00:   return 1'b1;
      2'b01:   return wp_n;
      default: return 1'b0;
    endcase
  endfunction

  // Keep only the lowest set request bit.
  function automatic logic [NCMD-1:0] lowest_req(input logic [NCMD-1:0] req);
    return req & (~req + NCMD'(1));
  endfunction
endpackage

// File: rtl/fsr_busy_timer.sv
module fsr_busy_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  logic [CNT_W-1:0] cnt_q;

  assign done = busy && (cnt_q == '0) && !abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (abort) begin
      busy  <= 1'b0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= CNT_W'(CYCLES - 1);
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/fsr_policy.sv
module fsr_policy
  import flash_sr_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int BLOCK_W = 16
) (
  input  logic [NCMD-1:0]   grant,
  input  logic [15:0]       status,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              grant_ok
);
  localparam int BLK_W = ADDR_W - BLOCK_W;
  localparam int unsigned NBLK = 1 << BLK_W;

  logic       busy, wel, addr_locked;
  logic [4:0] bp;
  logic [1:0] srp;

  assign busy = status[B_WIP];
  assign wel  = status[B_WEL];
  assign bp   = status[B_BPLO +: 5];
  assign srp  = status[B_SRP1:B_SRP0];
  assign addr_locked = in_protected(32'(addr[ADDR_W-1:BLOCK_W]), bp[2:0], NBLK);

  always_comb begin
    grant_ok = 1'b0;
    if (grant[C_WREN] || grant[C_WRDI])
      grant_ok = !busy;
    else if (grant[C_WRSR])
      grant_ok = !busy && wel && srp_permits(srp, wp_n);
    else if (grant[C_PP] || grant[C_SE] || grant[C_BE])
      grant_ok = !busy && wel && !addr_locked;
    else if (grant[C_CE])
      grant_ok = !busy && wel && (bp == 5'd0);
  end
endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
  import flash_sr_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int BLOCK_W     = 16,
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [15:0]       wrsr_data,
  input  logic              cmd_pp,
  input  logic              cmd_se,
  input  logic              cmd_be,
  input  logic              cmd_ce,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              wp_n,
  input  logic              power_cycle,
  output logic [15:0]       status_o,
  output logic [NCMD-1:0]   accept_o,
  output logic [NCMD-1:0]   reject_o
);
  logic [NCMD-1:0] req, grant;
  logic            grant_ok, take_cmd, start_op, busy, op_done;
  logic [15:2]     sr_q;
  logic            wel_q;

  assign req = {cmd_ce, cmd_be, cmd_se, cmd_pp, cmd_wrsr, cmd_wrdi, cmd_wren};
  assign grant = lowest_req(req);
  assign status_o = {sr_q, wel_q, busy};

  fsr_policy #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_policy (
    .grant(grant), .status(status_o), .wp_n(wp_n), .addr(cmd_addr),
    .grant_ok(grant_ok)
  );

  assign take_cmd = (|grant) && grant_ok && !power_cycle;
  assign start_op = take_cmd && (grant[C_WRSR] || grant[C_PP] || grant[C_SE] ||
                                 grant[C_BE] || grant[C_CE]);

  fsr_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start_op), .abort(power_cycle),
    .busy(busy), .done(op_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q     <= '0;
      wel_q    <= 1'b0;
      accept_o <= '0;
      reject_o <= '0;
    end else begin
      accept_o <= '0;
      reject_o <= '0;
      if (power_cycle) begin
        wel_q <= 1'b0;
        if (sr_q[B_SRP1:B_SRP0] == 2'b10) sr_q[B_SRP1:B_SRP0] <= 2'b00;
      end else begin
        if (op_done) wel_q <= 1'b0;
        if (take_cmd) begin
          accept_o <= grant;
          if (grant[C_WREN]) wel_q <= 1'b1;
          if (grant[C_WRDI]) wel_q <= 1'b0;
          if (grant[C_WRSR]) sr_q  <= wrsr_data[15:2];
        end else begin
          reject_o <= grant;
        end
      end
    end
  end
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [6:0]  req,
  input logic        power_cycle,
  input logic        busy,
  input logic        op_done,
  input logic [15:0] status_o,
  input logic [6:0]  accept_o,
  input logic [6:0]  reject_o
);
  p_one_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(accept_o | reject_o) && ((accept_o & reject_o) == 7'd0));

  p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (|req) && !power_cycle) |=>
      (accept_o == 7'd0) && (status_o[15:2] == $past(status_o[15:2])));

  p_wip_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> (status_o[1:0] == 2'b00));

  p_wel_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((req[1:0] == 2'b00) && (|req[6:2]) && !status_o[1] && !power_cycle)
      |=> (accept_o == 7'd0));

  p_lock_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[8:7] == 2'b11) |=> (status_o[8:7] == 2'b11));

  p_lockdown_revert_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (power_cycle && status_o[8:7] == 2'b10) |=> (status_o[8:7] == 2'b00));

  p_ce_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o[6] |-> ($past(status_o[6:2]) == 5'd0));

  p_pwr_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    power_cycle |=> (status_o[1:0] == 2'b00) && (accept_o == 7'd0) && (reject_o == 7'd0));
endmodule

bind flash_sr_guard fsr_checker u_fsr_checker (
  .clk(clk), .rst_n(rst_n), .req(req), .power_cycle(power_cycle),
  .busy(busy), .op_done(op_done), .status_o(status_o),
  .accept_o(accept_o), .reject_o(reject_o)
);

// File: tb/test_flash_sr_guard.sv
module test_flash_sr_guard;
  localparam int BUSY = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_be, cmd_ce;
  logic [15:0] wrsr_data;
  logic [18:0] cmd_addr;
  logic wp_n, power_cycle;
  logic [15:0] status_o;
  logic [6:0] accept_o, reject_o;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  flash_sr_guard #(.BUSY_CYCLES(BUSY)) i_flash_sr_guard (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .cmd_pp(cmd_pp),
    .cmd_se(cmd_se), .cmd_be(cmd_be), .cmd_ce(cmd_ce), .cmd_addr(cmd_addr),
    .wp_n(wp_n), .power_cycle(power_cycle), .status_o(status_o),
    .accept_o(accept_o), .reject_o(reject_o)
  );

  // bench model
  logic [15:2] m_sr;
  logic m_wel, m_busy;
  int m_left;

  function automatic int first_prot_block(input logic [2:0] bp);
    case (bp)
      3'd0: return 8;
      3'd1: return 7;
      3'd2: return 6;
      3'd3: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic bit sr_write_ok(input logic [1:0] mode, input logic pin);
    if (mode == 2'b00) return 1'b1;
    if (mode == 2'b01) return pin;
    return 1'b0;
  endfunction

  task automatic drive(input logic [6:0] rq, input logic [15:0] d,
                       input logic [18:0] a, input logic wp, input logic pc);
    {cmd_ce, cmd_be, cmd_se, cmd_pp, cmd_wrsr, cmd_wrdi, cmd_wren} = rq;
    wrsr_data = d; cmd_addr = a; wp_n = wp; power_cycle = pc;
  endtask

  task automatic step(input logic [6:0] rq, input logic [15:0] d,
                      input logic [18:0] a, input logic wp, input logic pc,
                      input string tag);
    int g;
    bit ok;
    logic [6:0] e_acc, e_rej;
    logic [15:0] e_st;
    drive(rq, d, a, wp, pc);
    g = -1;
    for (int i = 6; i >= 0; i--) if (rq[i]) g = i;
    e_acc = '0; e_rej = '0;
    if (pc) begin
      m_wel = 1'b0; m_busy = 1'b0;
      if (m_sr[8:7] == 2'b10) m_sr[8:7] = 2'b00;
    end else begin
      ok = 1'b0;
      if (g >= 0 && !m_busy) begin
        case (g)
          0, 1: ok = 1'b1;
          2: ok = m_wel && sr_write_ok(m_sr[8:7], wp);
          3, 4, 5: ok = m_wel && (int'(a[18:16]) < first_prot_block(m_sr[4:2]));
          default: ok = m_wel && (m_sr[6:2] == 5'd0);
        endcase
      end
      if (g >= 0) begin
        if (ok) e_acc[g] = 1'b1; else e_rej[g] = 1'b1;
      end
      if (m_busy) begin
        if (m_left == 0) begin m_busy = 1'b0; m_wel = 1'b0; end
        else m_left--;
      end
      if (ok) begin
        if (g == 0) m_wel = 1'b1;
        if (g == 1) m_wel = 1'b0;
        if (g == 2) m_sr = d[15:2];
        if (g >= 2) begin m_busy = 1'b1; m_left = BUSY - 1; end
      end
    end
    e_st = {m_sr, m_wel, m_busy};
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (status_o !== e_st || accept_o !== e_acc || reject_o !== e_rej) begin
      failures++;
      $display("FAIL %s: status=%h exp %h accept=%b exp %b reject=%b exp %b",
               tag, status_o, e_st, accept_o, e_acc, reject_o, e_rej);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(7'd0, 16'd0, 19'd0, 1'b1, 1'b0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    drive(7'd0, 16'd0, 19'd0, 1'b1, 1'b0);
    m_sr = '0; m_wel = 1'b0; m_busy = 1'b0; m_left = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic sr_set(input logic [15:0] d, input string tag);
    step(7'b0000001, 16'd0, 19'd0, 1'b1, 1'b0, tag);
    step(7'b0000100, d, 19'd0, 1'b1, 1'b0, tag);
    idle(BUSY, tag);
  endtask

  localparam logic [6:0] WREN = 7'b0000001, WRDI = 7'b0000010, WRSR = 7'b0000100,
                         PP = 7'b0001000, SE = 7'b0010000, BE = 7'b0100000,
                         CE = 7'b1000000;

  initial begin
    int unsigned seed = 32'd12345;
    logic [15:0] rd;
    logic [6:0] rq;
    void'($urandom(seed));
    drive(7'd0, 16'd0, 19'd0, 1'b1, 1'b0);
    do_reset();
    idle(1, "R1 reset state");
    step(WREN, 0, 0, 1, 0, "R2 write enable");
    step(WRDI, 0, 0, 1, 0, "R2 write disable");
    step(WRSR, 16'h0E03, 0, 1, 0, "R3 status write without WEL");
    step(PP, 0, 19'h10000, 1, 0, "R3 program without WEL");
    step(CE, 0, 0, 1, 0, "R3 chip erase without WEL");
    step(WREN, 0, 0, 1, 0, "R4 enable");
    step(WRSR, 16'h0E03, 0, 0, 0, "R4 mode 00 pin low accepted");
    idle(BUSY - 1, "R11 busy window");
    step(WREN, 0, 0, 1, 0, "R11 strobe in last busy cycle");
    step(WREN, 0, 0, 1, 0, "R11 strobe after busy");
    step(WRSR, 16'h0080, 0, 1, 0, "R4 set mode 01");
    idle(BUSY, "R11 idle");
    step(WREN, 0, 0, 1, 0, "R5 enable");
    step(WRSR, 16'h0000, 0, 0, 0, "R5 mode 01 pin low rejected");
    step(WRSR, 16'h0100, 0, 1, 0, "R5 mode 01 pin high accepted");
    idle(BUSY, "R5 idle");
    step(WREN, 0, 0, 1, 0, "R6 enable");
    step(WRSR, 16'h0000, 0, 1, 0, "R6 lockdown rejects");
    step(0, 0, 0, 1, 1, "R6 power cycle reverts mode");
    step(WREN, 0, 0, 1, 1, "R8 strobe with power cycle dropped");
    sr_set(16'h0004, "R9 set BP=1");
    step(WREN, 0, 0, 1, 0, "R9 enable");
    step(PP, 0, 19'h70000, 1, 0, "R9 top block protected");
    step(PP, 0, 19'h6FFFF, 1, 0, "R9 block 6 open");
    idle(BUSY, "R9 idle");
    sr_set(16'h000C, "R9 set BP=3");
    step(WREN, 0, 0, 1, 0, "R9 enable");
    step(SE, 0, 19'h40000, 1, 0, "R9 block 4 protected");
    step(CE, 0, 0, 1, 0, "R10 chip erase with BP=3");
    step(BE, 0, 19'h3FFFF, 1, 0, "R9 block 3 open");
    step(0, 0, 0, 1, 1, "R8 power cycle during erase");
    sr_set(16'h001C, "R9 set BP=7");
    step(WREN, 0, 0, 1, 0, "R9 enable");
    step(PP, 0, 19'h00000, 1, 0, "R9 BP=7 whole array");
    sr_set(16'h0020, "R10 set BP3 only");
    step(WREN, 0, 0, 1, 0, "R10 enable");
    step(CE, 0, 0, 1, 0, "R10 chip erase with upper BP bit");
    step(PP, 0, 19'h70000, 1, 0, "R9 upper BP bit leaves map open");
    idle(BUSY, "R9 idle");
    sr_set(16'h0000, "R10 clear BP");
    step(WREN | PP, 0, 19'h70000, 1, 0, "R12 enable wins over program");
    step(CE, 0, 0, 1, 0, "R10 chip erase with BP clear");
    idle(BUSY, "R10 idle");
    step(WRDI | WRSR, 16'h0180, 0, 1, 0, "R12 disable wins over status write");
    sr_set(16'h0180, "R7 set mode 11");
    step(WREN, 0, 0, 1, 0, "R7 enable");
    step(WRSR, 16'h0000, 0, 1, 0, "R7 permanent reject");
    step(0, 0, 0, 1, 1, "R7 power cycle keeps mode");
    step(WREN, 0, 0, 1, 0, "R7 enable");
    step(WRSR, 16'h0000, 0, 1, 0, "R7 still rejected");

    for (int n = 0; n < 4000; n++) begin
      if (n % 800 == 0) do_reset();
      rq = 7'd0;
      if ($urandom_range(99) < 45) begin
        rq[$urandom_range(6)] = 1'b1;
        if ($urandom_range(99) < 10) rq[$urandom_range(6)] = 1'b1;
      end
      rd = 16'($urandom);
      if (rd[8:7] == 2'b11 && $urandom_range(99) < 90) rd[8] = 1'b0;
      step(rq, rd, 19'($urandom), 1'($urandom), ($urandom_range(99) < 3),
           "random mix");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule